// File: doc/BRIEF.md
# Two-Level Pipelined Issue Select

This block picks one ready entry per cycle from an issue queue split into four segments of eight entries each. Every entry raises a ready request, and the block answers with a single grant: a valid flag and the flat entry index. Entries in the first segment (indices 0 to 7) compete directly in the final arbiter in the cycle they request. Entries in the three deeper segments compete first inside their own segment. The winner of each segment is held in a register and enters the final arbiter in the following cycle. So a deep entry waits one cycle longer than a front entry.

A clear input removes entries from the queue. A cleared entry is never granted. This holds when it is in the front segment, when it is being captured as a candidate, and when it is waiting in a candidate register. An entry granted out of a candidate register is also kept out of the capture that happens in the same cycle. Because of this, an entry whose request is still high cannot be granted again in the next cycle. The requester is expected to drop the request of a granted entry.

Top module: `seg_issue_select`

## Requirements
- R1: A live request (req set, clr clear) in segment 0 (indices 0..7) is granted combinationally in the same cycle.
- R2: A request in segments 1..3 (indices 8..31) is never granted in the cycle it first appears. It is granted in the next cycle through that segment's registered candidate.
- R3: Within a segment, the live request with the lowest index wins. This applies both to segment 0 and to the pre-select of segments 1..3.
- R4: Any live segment-0 request takes the grant ahead of all registered candidates.
- R5: Among valid candidates, the one from the lower-numbered segment wins.
- R6: An entry granted from a candidate register is left out of that cycle's pre-select capture. It is not granted again in the following cycle, even if its request stays high.
- R7: An entry whose clr bit is set is not granted in that cycle. The same clr also stops the entry from being captured as a candidate, and it cancels a candidate already waiting in a register.
- R8: While rst_n is low, gnt_vld is 0 and all candidate registers are emptied. In the first cycle after reset, only segment-0 requests can be granted.
- R9: At most one grant is issued per cycle. gnt_idx is 5 bits wide, equal to segment*8 + slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 32 | Ready request per entry, bit i = entry i |
| clr | input | 32 | Removes entry i in this cycle |
| gnt_vld | output | 1 | A grant is issued this cycle |
| gnt_idx | output | 5 | Flat index of the granted entry |

## Verification
Two events can fall in the same cycle: a same-cycle segment-0 request and a candidate that waited one cycle in its register. The bench provokes this by raising a deep request and then adding a front request in the next cycle. It then expects the front entry to win, and the waiting candidate to be recaptured and granted one cycle later. A second collision is a grant from a candidate register in the same cycle as that segment's recapture. The bench holds the granted request high and expects the next lower-priority candidate, not a repeat grant. A third is a clear that lands on an entry in the very cycle it sits in a candidate register. The bench judges this by seeing no grant at all.

// File: rtl/seg_issue_select.sv
module seg_issue_select #(
  parameter int SEGS  = 4,
  parameter int SEG_W = 8,
  localparam int N      = SEGS * SEG_W,
  localparam int IDX_W  = $clog2(N),
  localparam int SLOT_W = $clog2(SEG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     clr,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);

  function automatic logic [SLOT_W:0] pick_low(input logic [SEG_W-1:0] v);
    logic [SLOT_W:0] r;
    r = '0;
    for (int i = SEG_W - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, SLOT_W'(i)};
    return r;
  endfunction

  logic [N-1:0]      live;
  logic [N-1:0]      gnt_mask;
  logic [SLOT_W:0]   front;
  logic              cand_v    [SEGS];
  logic [SLOT_W-1:0] cand_slot [SEGS];
  logic              cand_ok   [SEGS];
  logic              any_vld;
  logic [IDX_W-1:0]  any_idx;

  assign live  = req & ~clr;
  assign front = pick_low(live[SEG_W-1:0]);

  assign cand_v[0]    = 1'b0;
  assign cand_slot[0] = '0;
  assign cand_ok[0]   = 1'b0;

  genvar s;
  generate
    for (s = 1; s < SEGS; s++) begin : g_seg
      logic [SLOT_W:0] pick;
      assign pick = pick_low(live[s*SEG_W +: SEG_W] & ~gnt_mask[s*SEG_W +: SEG_W]);
      assign cand_ok[s] = cand_v[s] & ~clr[s*SEG_W + int'(cand_slot[s])];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cand_v[s]    <= 1'b0;
          cand_slot[s] <= '0;
        end else begin
          cand_v[s]    <= pick[SLOT_W];
          cand_slot[s] <= pick[SLOT_W-1:0];
        end
      end
    end
  endgenerate

  always_comb begin
    any_vld = 1'b0;
    any_idx = '0;
    if (front[SLOT_W]) begin
      any_vld = 1'b1;
      any_idx = IDX_W'(front[SLOT_W-1:0]);
    end else begin
      for (int k = SEGS - 1; k >= 1; k--)
        if (cand_ok[k]) begin
          any_vld = 1'b1;
          any_idx = IDX_W'(k * SEG_W) + IDX_W'(cand_slot[k]);
        end
    end
  end

  assign gnt_vld  = rst_n & any_vld;
  assign gnt_idx  = any_idx;
  assign gnt_mask = gnt_vld ? ({{(N-1){1'b0}}, 1'b1} << gnt_idx) : '0;

endmodule

module seg_issue_select_chk #(
  parameter int SEGS  = 4,
  parameter int SEG_W = 8,
  localparam int N      = SEGS * SEG_W,
  localparam int IDX_W  = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req,
  input logic [N-1:0]     clr,
  input logic             gnt_vld,
  input logic [IDX_W-1:0] gnt_idx
);
  logic [N-1:0]     req_d;
  logic             deep_d;
  logic [IDX_W-1:0] idx_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d  <= '0;
      deep_d <= 1'b0;
      idx_d  <= '0;
    end else begin
      req_d  <= req & ~clr;
      deep_d <= gnt_vld && (int'(gnt_idx) >= SEG_W);
      idx_d  <= gnt_idx;
    end
  end

  // R8
  always @(posedge clk) begin
    reset_quiet_chk: assert (rst_n || !gnt_vld);
  end

  // R1
  front_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req[SEG_W-1:0] & ~clr[SEG_W-1:0])) |-> (gnt_vld && int'(gnt_idx) < SEG_W));

  // R3
  front_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && int'(gnt_idx) < SEG_W) |->
      (((req[SEG_W-1:0] & ~clr[SEG_W-1:0]) & ((SEG_W'(1) << gnt_idx) - SEG_W'(1))) == '0));

  // R2
  deep_needs_prior_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && int'(gnt_idx) >= SEG_W) |-> req_d[gnt_idx]);

  // R7
  no_cleared_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> !clr[gnt_idx]);

  // R6
  no_repeat_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_d && gnt_vld) |-> (gnt_idx != idx_d));
endmodule

bind seg_issue_select seg_issue_select_chk #(.SEGS(SEGS), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .clr(clr), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
);

// File: tb/seg_issue_select_tb.sv
module seg_issue_select_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic [31:0] clr = '0;
  logic        gnt_vld;
  logic [4:0]  gnt_idx;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_issue_select u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .clr(clr), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  function automatic logic [31:0] b(input int i);
    return 32'd1 << i;
  endfunction

  task automatic chk(input string r, input logic ev, input int ei);
    n_chk++;
    if (gnt_vld !== ev || (ev && int'(gnt_idx) != ei)) begin
      n_fail++;
      $display("FAIL %s: got vld=%0b idx=%0d, expected vld=%0b idx=%0d", r, gnt_vld, gnt_idx, ev, ei);
    end
  endtask

  task automatic cyc(input logic [31:0] r, input logic [31:0] c);
    @(negedge clk);
    req = r;
    clr = c;
    #1;
  endtask

  task automatic idle();
    cyc('0, '0);
    cyc('0, '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc('1, '0);
    chk("R8 during reset", 1'b0, 0);
    cyc('1, '0);
    chk("R8 during reset held", 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    req = '0;
    #1;
    chk("R8 first cycle after reset", 1'b0, 0);
    cyc('0, '0);
    chk("R8 no candidate survives reset", 1'b0, 0);
  endtask

  task automatic t_front();
    cyc(b(5) | b(2), '0);
    chk("R1 R3 front lowest same cycle", 1'b1, 2);
    cyc(b(7), '0);
    chk("R1 front single", 1'b1, 7);
    idle();
  endtask

  task automatic t_deep();
    cyc(b(12), '0);
    chk("R2 deep not granted first cycle", 1'b0, 0);
    cyc('0, '0);
    chk("R2 deep granted next cycle", 1'b1, 12);
    cyc(b(13) | b(10), '0);
    chk("R2 pair first cycle", 1'b0, 0);
    cyc('0, '0);
    chk("R3 deep lowest slot", 1'b1, 10);
    idle();
  endtask

  task automatic t_prio();
    cyc(b(12), '0);
    cyc(b(12) | b(6), '0);
    chk("R4 front beats candidate", 1'b1, 6);
    cyc(b(12), '0);
    chk("R4 candidate after front", 1'b1, 12);
    idle();
  endtask

  task automatic t_segprio();
    cyc(b(30) | b(20), '0);
    cyc(b(30) | b(20), '0);
    chk("R5 lower segment wins", 1'b1, 20);
    cyc(b(30) | b(20), '0);
    chk("R6 no regrant of held entry", 1'b1, 30);
    idle();
  endtask

  task automatic t_clear();
    cyc(b(17), '0);
    cyc(b(17), b(17));
    chk("R7 waiting candidate cleared", 1'b0, 0);
    cyc('0, '0);
    chk("R7 cleared entry not recaptured", 1'b0, 0);
    cyc(b(18), b(18));
    cyc('0, '0);
    chk("R7 clear at capture", 1'b0, 0);
    cyc(b(2), b(2));
    chk("R7 front cleared", 1'b0, 0);
    cyc(b(2) | b(4), b(2));
    chk("R7 front next live", 1'b1, 4);
    idle();
  endtask

  task automatic t_index();
    cyc(b(31), '0);
    cyc('0, '0);
    chk("R9 top index", 1'b1, 31);
    cyc(b(8), '0);
    cyc('0, '0);
    chk("R9 first deep index", 1'b1, 8);
    cyc(b(0) | b(27), '0);
    chk("R9 index zero", 1'b1, 0);
    idle();
  endtask

  task automatic t_midreset();
    cyc(b(25), '0);
    @(negedge clk);
    rst_n = 1'b0;
    req = '0;
    #1;
    chk("R8 reset masks waiting candidate", 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 candidate emptied by reset", 1'b0, 0);
    idle();
  endtask

  initial begin
    t_reset();
    t_front();
    t_deep();
    t_prio();
    t_segprio();
    t_clear();
    t_index();
    t_midreset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule